// File: doc/BRIEF.md
# Flash Access Gate with Programming Interlock

This block stands between user logic and an on-chip user flash macro. User logic asks for one command at a time: address shift, data shift, read, write or erase. The gate forwards each command to the flash as a one-cycle strobe and waits for the flash completion pulse before it accepts the next command. It also works with an external in-system programming controller in two ways. It reports through `isp_safe` whether a programming session may begin. It also freezes all user flash traffic while the controller's busy line is high.

Writes and erases are the long operations. `isp_safe` drops in the cycle a write or erase is strobed and stays low until that operation has finished. An erase is treated as finished only when two things are true: the flash has pulsed done, and at least `ERASE_CYCLES` clocks have passed since the strobe. That window is the sector-erase time that the programming controller also waits out. Short operations never lower `isp_safe`.

A session request (`isp_request`, held high) is granted with `isp_ack` when no write or erase is in flight. The request may stand for verify, examine, security setting or a readback. If a long operation is in flight when the request arrives, `isp_err` rises and the grant waits until the operation drains. A user request that meets a blocking condition is held inside the gate, not dropped. The blocking conditions are: busy high, a session requested, or a session active.

The command sequencer has four states:
- SQ_IDLE: waiting for a request.
- SQ_HOLD: a command is captured but blocked.
- SQ_ISSUE: the strobe cycle.
- SQ_WAIT: waiting for completion.

Its transitions are:
- IDLE→ISSUE when a request arrives and nothing blocks it.
- IDLE→HOLD when a request arrives and something blocks it.
- HOLD→ISSUE when the block clears.
- ISSUE→HOLD when a block appears in the strobe cycle.
- ISSUE→WAIT otherwise.
- WAIT→IDLE on completion.

The session arbiter has three states:
- ARB_OFF: no session requested.
- ARB_STALL: a request is waiting behind a long operation.
- ARB_ON: the session is granted.

Its transitions are:
- OFF→ON when a request arrives and nothing long is in flight.
- OFF→STALL when a request arrives during a long operation.
- STALL→ON when the long operation ends.
- STALL→OFF and ON→OFF when the request drops.

Top module: `flash_isp_gate`

## Requirements
- R1: A synchronous active-low reset returns both state machines to idle and discards any held user command. After reset, `isp_safe`=1 and `fl_valid`, `usr_ready`, `isp_ack` and `isp_err` are all 0.
- R2: Command codes are 0 address shift, 1 data shift, 2 read, 3 write and 4 erase. A request seen in idle with nothing blocking is strobed in the next cycle. In that cycle `fl_valid`=`usr_ready`=1 for one cycle, and `fl_cmd` equals the requested code.
- R3: Only one command is outstanding at a time. The operation ends in the WAIT cycle where its completion condition holds. A request held across the end of an operation is strobed two cycles after that WAIT cycle.
- R4: `isp_safe` is low from the strobe cycle of a write until the cycle after the write's done pulse. A write whose done pulse arrives L cycles after the strobe holds `isp_safe` low for L+1 cycles.
- R5: An erase ends no sooner than `ERASE_CYCLES` cycles after its strobe and no sooner than its done pulse. It holds `isp_safe` low for 1+max(L, `ERASE_CYCLES`) cycles.
- R6: Address shift, data shift and read never lower `isp_safe`.
- R7: While `prog_busy`=1 no command of any class is strobed, and `usr_ready` stays 0. A held request is strobed in the cycle after `prog_busy` falls.
- R8: A session request made with no write or erase in flight is granted one cycle later. The grant holds while the request holds. No user command is strobed while a session is requested or granted, nor in the cycle after the grant ends.
- R9: A session request made during a write or erase raises `isp_err` and keeps `isp_ack` low. The grant follows one cycle after `isp_safe` returns high, and at that point `isp_err` clears.
- R10: A read in flight does not delay a session grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| usr_req | input | 1 | User command request, held until `usr_ready` |
| usr_cmd | input | 3 | User command code |
| usr_ready | output | 1 | Pulses in the cycle the user command is strobed |
| fl_valid | output | 1 | Command strobe to the flash macro |
| fl_cmd | output | 3 | Command code to the flash macro |
| fl_done | input | 1 | Completion pulse from the flash macro |
| prog_busy | input | 1 | Busy flag from the programming controller |
| isp_request | input | 1 | Session request, level |
| isp_ack | output | 1 | Session granted |
| isp_err | output | 1 | Session requested during a write or erase |
| isp_safe | output | 1 | No write or erase in flight |

## Verification
A sequencer stuck in WAIT or HOLD shows up as a missing `fl_valid` for a held request. A duplicated strobe shows up as a second `fl_valid` before the done pulse. Either is visible within one operation length. A wrong erase timer moves the rising edge of `isp_safe` off the cycle 1+max(L, `ERASE_CYCLES`) after the strobe, so the error appears in that same erase. A wrong arbiter state shows up as a grant during a long operation, or as a missing `isp_err`. Both are visible one cycle after the request.

// File: rtl/flash_gate_pkg.sv
package flash_gate_pkg;
    localparam int CMD_W = 3;

    typedef enum logic [CMD_W-1:0] {
        CMD_ADDR  = 3'd0,
        CMD_DATA  = 3'd1,
        CMD_READ  = 3'd2,
        CMD_WRITE = 3'd3,
        CMD_ERASE = 3'd4
    } cmd_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_HOLD,
        SQ_ISSUE,
        SQ_WAIT
    } seq_state_t;

    typedef enum logic [1:0] {
        ARB_OFF,
        ARB_STALL,
        ARB_ON
    } arb_state_t;

    function automatic logic is_long(input logic [CMD_W-1:0] c);
        return (c == CMD_WRITE) || (c == CMD_ERASE);
    endfunction
endpackage

// File: rtl/erase_timer.sv
module erase_timer #(
    parameter int ERASE_CYCLES = 50_000_000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic expired
);
    localparam int CNT_W = $clog2(ERASE_CYCLES + 1);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            remain_q <= '0;
        else if (start)
            remain_q <= CNT_W'(ERASE_CYCLES - 1);
        else if (remain_q != '0)
            remain_q <= remain_q - 1'b1;
    end

    assign expired = (remain_q == '0);
endmodule

// File: rtl/isp_arbiter.sv
module isp_arbiter
    import flash_gate_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic isp_request,
    input  logic long_active,
    output logic isp_ack,
    output logic isp_err,
    output logic session_hold
);
    arb_state_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ARB_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_OFF:   if (isp_request) state_d = long_active ? ARB_STALL : ARB_ON;
            ARB_STALL: if (!isp_request) state_d = ARB_OFF;
                       else if (!long_active) state_d = ARB_ON;
            ARB_ON:    if (!isp_request) state_d = ARB_OFF;
            default:   state_d = ARB_OFF;
        endcase
    end

    always_comb begin
        isp_ack      = (state_q == ARB_ON);
        isp_err      = (state_q == ARB_STALL);
        session_hold = (state_q != ARB_OFF);
    end
endmodule

// File: rtl/cmd_sequencer.sv
module cmd_sequencer
    import flash_gate_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usr_req,
    input  logic [CMD_W-1:0] usr_cmd,
    input  logic             gate,
    input  logic             fl_done,
    input  logic             erase_expired,
    output logic             fl_valid,
    output logic [CMD_W-1:0] fl_cmd,
    output logic             usr_ready,
    output logic             long_active,
    output logic             erase_start
);
    seq_state_t       state_q, state_d;
    logic [CMD_W-1:0] cmd_q;
    logic             done_seen_q;
    logic             finish;
    logic             strobe;

    assign strobe = (state_q == SQ_ISSUE) && !gate;
    assign finish = (done_seen_q || fl_done) &&
                    ((cmd_q != CMD_ERASE) || erase_expired);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= SQ_IDLE;
            cmd_q       <= '0;
            done_seen_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == SQ_IDLE && usr_req)
                cmd_q <= usr_cmd;
            if (strobe)
                done_seen_q <= 1'b0;
            else if (state_q == SQ_WAIT && fl_done)
                done_seen_q <= 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE:  if (usr_req) state_d = gate ? SQ_HOLD : SQ_ISSUE;
            SQ_HOLD:  if (!gate)   state_d = SQ_ISSUE;
            SQ_ISSUE: state_d = gate ? SQ_HOLD : SQ_WAIT;
            SQ_WAIT:  if (finish)  state_d = SQ_IDLE;
            default:  state_d = SQ_IDLE;
        endcase
    end

    always_comb begin
        fl_valid    = strobe;
        usr_ready   = strobe;
        fl_cmd      = cmd_q;
        erase_start = strobe && (cmd_q == CMD_ERASE);
        long_active = (strobe || state_q == SQ_WAIT) && is_long(cmd_q);
    end
endmodule

// File: rtl/flash_isp_gate.sv
module flash_isp_gate
    import flash_gate_pkg::*;
#(
    parameter int ERASE_CYCLES = 50_000_000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             usr_req,
    input  logic [CMD_W-1:0] usr_cmd,
    output logic             usr_ready,
    output logic             fl_valid,
    output logic [CMD_W-1:0] fl_cmd,
    input  logic             fl_done,
    input  logic             prog_busy,
    input  logic             isp_request,
    output logic             isp_ack,
    output logic             isp_err,
    output logic             isp_safe
);
    logic long_active;
    logic session_hold;
    logic erase_start;
    logic erase_expired;
    logic gate;

    assign gate     = prog_busy || isp_request || session_hold;
    assign isp_safe = !long_active;

    cmd_sequencer u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .usr_req       (usr_req),
        .usr_cmd       (usr_cmd),
        .gate          (gate),
        .fl_done       (fl_done),
        .erase_expired (erase_expired),
        .fl_valid      (fl_valid),
        .fl_cmd        (fl_cmd),
        .usr_ready     (usr_ready),
        .long_active   (long_active),
        .erase_start   (erase_start)
    );

    isp_arbiter u_arb (
        .clk          (clk),
        .rst_n        (rst_n),
        .isp_request  (isp_request),
        .long_active  (long_active),
        .isp_ack      (isp_ack),
        .isp_err      (isp_err),
        .session_hold (session_hold)
    );

    erase_timer #(.ERASE_CYCLES(ERASE_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (erase_start),
        .expired (erase_expired)
    );
endmodule

// File: rtl/flash_isp_gate_chk.sv
module flash_isp_gate_chk
    import flash_gate_pkg::*;
#(
    parameter int ERASE_CYCLES = 50_000_000
) (
    input logic             clk,
    input logic             rst_n,
    input logic             fl_valid,
    input logic [CMD_W-1:0] fl_cmd,
    input logic             fl_done,
    input logic             prog_busy,
    input logic             isp_ack,
    input logic             isp_safe
);
    logic        outstanding_q;
    logic        erase_track_q;
    logic [31:0] erase_cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            outstanding_q <= 1'b0;
            erase_track_q <= 1'b0;
            erase_cnt_q   <= '0;
        end else begin
            if (fl_valid)     outstanding_q <= 1'b1;
            else if (fl_done) outstanding_q <= 1'b0;
            if (fl_valid && fl_cmd == CMD_ERASE) begin
                erase_track_q <= 1'b1;
                erase_cnt_q   <= '0;
            end else if (erase_track_q) begin
                if (isp_safe) erase_track_q <= 1'b0;
                else          erase_cnt_q   <= erase_cnt_q + 1;
            end
        end
    end

    // R3
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fl_valid |-> !outstanding_q);

    // R7
    busy_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        prog_busy |-> !fl_valid);

    // R4
    long_unsafe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fl_valid && is_long(fl_cmd)) |-> !isp_safe);

    // R8
    session_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        isp_ack |-> !fl_valid);

    // R9
    grant_after_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(isp_ack) |-> $past(isp_safe));

    // R5
    erase_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_track_q && isp_safe) |-> (erase_cnt_q >= 32'(ERASE_CYCLES)));
endmodule

bind flash_isp_gate flash_isp_gate_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .fl_valid  (fl_valid),
    .fl_cmd    (fl_cmd),
    .fl_done   (fl_done),
    .prog_busy (prog_busy),
    .isp_ack   (isp_ack),
    .isp_safe  (isp_safe)
);

// File: tb/flash_isp_gate_bench.sv
`timescale 1ns/1ps
module flash_isp_gate_bench;
    localparam int ERASE = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       usr_req = 1'b0;
    logic [2:0] usr_cmd = '0;
    logic       usr_ready;
    logic       fl_valid;
    logic [2:0] fl_cmd;
    logic       fl_done;
    logic       prog_busy = 1'b0;
    logic       isp_request = 1'b0;
    logic       isp_ack;
    logic       isp_err;
    logic       isp_safe;

    int vectors = 0;
    int miscompares = 0;
    int flash_lat = 1;
    int rem = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    flash_isp_gate #(.ERASE_CYCLES(ERASE)) u_flash_isp_gate (
        .clk(clk), .rst_n(rst_n), .usr_req(usr_req), .usr_cmd(usr_cmd),
        .usr_ready(usr_ready), .fl_valid(fl_valid), .fl_cmd(fl_cmd),
        .fl_done(fl_done), .prog_busy(prog_busy), .isp_request(isp_request),
        .isp_ack(isp_ack), .isp_err(isp_err), .isp_safe(isp_safe)
    );

    // flash model: done pulse flash_lat cycles after the strobe
    always @(posedge clk) begin
        if (fl_valid)     rem <= flash_lat;
        else if (rem > 0) rem <= rem - 1;
    end
    assign fl_done = (rem == 1);

    task automatic cyc();
        @(posedge clk);
        #1;
    endtask

    task automatic expect_eq(string tag, int act, int exp);
        vectors++;
        if (act != exp) begin
            miscompares++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic drain(int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    // R2 R3 R4 R5 R6: strobe a command, hold a read request behind it
    task automatic run_pair(int c, int lat);
        int w, low, second;
        bit lng;
        flash_lat = lat;
        lng = (c == 3) || (c == 4);
        w = (c == 4 && ERASE > lat) ? ERASE : lat;
        usr_cmd = 3'(c);
        usr_req = 1'b1;
        cyc();
        expect_eq("R2 fl_valid", int'(fl_valid), 1);
        expect_eq("R2 usr_ready", int'(usr_ready), 1);
        expect_eq("R2 fl_cmd", int'(fl_cmd), c);
        low = isp_safe ? 0 : 1;
        usr_cmd = 3'd2;
        second = -1;
        for (int k = 1; k <= w + 4; k++) begin
            cyc();
            if (second < 0 && fl_valid) begin
                second = k;
                usr_req = 1'b0;
            end
            if (second < 0 && !isp_safe) low++;
        end
        expect_eq("R3 next strobe cycle", second, w + 2);
        if (c == 3)      expect_eq("R4 write unsafe cycles", low, lat + 1);
        else if (c == 4) expect_eq("R5 erase unsafe cycles", low, w + 1);
        else             expect_eq("R6 short op unsafe cycles", low, 0);
        usr_req = 1'b0;
        drain(lat + 4);
    endtask

    // R7: held behind busy, strobed the cycle after busy falls
    task automatic run_busy(int c);
        flash_lat = 2;
        prog_busy = 1'b1;
        usr_cmd = 3'(c);
        usr_req = 1'b1;
        for (int k = 0; k < 6; k++) begin
            cyc();
            expect_eq("R7 no strobe while busy", int'(fl_valid), 0);
            expect_eq("R7 ready low while busy", int'(usr_ready), 0);
        end
        prog_busy = 1'b0;
        cyc();
        expect_eq("R7 strobe after busy falls", int'(fl_valid), 1);
        expect_eq("R7 held code", int'(fl_cmd), c);
        usr_req = 1'b0;
        drain(ERASE + 6);
    endtask

    // R9: session requested during a long operation
    task automatic run_isp_long(int c, int lat);
        int w;
        bit granted, saw_safe;
        flash_lat = lat;
        w = (c == 4 && ERASE > lat) ? ERASE : lat;
        usr_cmd = 3'(c);
        usr_req = 1'b1;
        cyc();
        usr_req = 1'b0;
        cyc();
        isp_request = 1'b1;
        for (int k = 2; k <= w; k++) begin
            cyc();
            expect_eq("R9 error while draining", int'(isp_err), 1);
            expect_eq("R9 no grant while draining", int'(isp_ack), 0);
        end
        cyc();
        expect_eq("R9 safe after drain", int'(isp_safe), 1);
        expect_eq("R9 grant waits one cycle", int'(isp_ack), 0);
        cyc();
        expect_eq("R9 grant", int'(isp_ack), 1);
        expect_eq("R9 error cleared", int'(isp_err), 0);
        isp_request = 1'b0;
        drain(3);
    endtask

    initial begin
        #(4 * 200000);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        drain(3);
        // R1 reset state
        expect_eq("R1 isp_safe", int'(isp_safe), 1);
        expect_eq("R1 fl_valid", int'(fl_valid), 0);
        expect_eq("R1 isp_ack", int'(isp_ack), 0);
        expect_eq("R1 isp_err", int'(isp_err), 0);
        expect_eq("R1 usr_ready", int'(usr_ready), 0);
        rst_n = 1'b1;
        cyc();

        for (int c = 0; c < 5; c++) begin
            run_pair(c, 1);
            run_pair(c, 4);
            run_pair(c, ERASE + 6);
        end

        for (int c = 0; c < 5; c++) run_busy(c);

        // R8 grant with nothing in flight, commands frozen meanwhile
        isp_request = 1'b1;
        cyc();
        expect_eq("R8 grant", int'(isp_ack), 1);
        expect_eq("R8 no error", int'(isp_err), 0);
        usr_cmd = 3'd4;
        usr_req = 1'b1;
        for (int k = 0; k < 4; k++) begin
            cyc();
            expect_eq("R8 no strobe in session", int'(fl_valid), 0);
            expect_eq("R8 grant held", int'(isp_ack), 1);
        end
        isp_request = 1'b0;
        cyc();
        expect_eq("R8 grant released", int'(isp_ack), 0);
        expect_eq("R8 no strobe on release", int'(fl_valid), 0);
        cyc();
        expect_eq("R8 strobe after session", int'(fl_valid), 1);
        usr_req = 1'b0;
        drain(ERASE + 4);

        run_isp_long(3, 10);
        run_isp_long(4, 1);
        run_isp_long(4, ERASE + 5);

        // R10 read in flight does not delay the grant
        flash_lat = 10;
        usr_cmd = 3'd2;
        usr_req = 1'b1;
        cyc();
        usr_req = 1'b0;
        cyc();
        isp_request = 1'b1;
        cyc();
        expect_eq("R10 grant during read", int'(isp_ack), 1);
        expect_eq("R10 no error during read", int'(isp_err), 0);
        isp_request = 1'b0;
        drain(14);

        // R1 reset discards a held command
        prog_busy = 1'b1;
        usr_cmd = 3'd3;
        usr_req = 1'b1;
        drain(2);
        rst_n = 1'b0;
        usr_req = 1'b0;
        cyc();
        rst_n = 1'b1;
        prog_busy = 1'b0;
        for (int k = 0; k < 5; k++) begin
            cyc();
            expect_eq("R1 held command discarded", int'(fl_valid), 0);
        end

        // R1 reset during an erase restores isp_safe
        flash_lat = 1;
        usr_cmd = 3'd4;
        usr_req = 1'b1;
        cyc();
        usr_req = 1'b0;
        drain(3);
        expect_eq("R1 erase in flight", int'(isp_safe), 0);
        rst_n = 1'b0;
        cyc();
        expect_eq("R1 safe after reset", int'(isp_safe), 1);
        rst_n = 1'b1;
        drain(3);

        finished = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule